// File: doc/BRIEF.md
# Two-Cycle Ternary Bit-Manipulation Unit

This unit is a multicycle companion to a 32-bit integer ALU. It executes six bit-manipulation operations: conditional mix, conditional move, left and right rotate, and left and right funnel shift. Three of them read three source words. The unit fits these onto a two-operand datapath by spending two clock cycles on every operation and parking the partial result in one internal stage register between the cycles.

A pipeline raises `start_i` with the opcode and the three source words and holds them for two cycles. In the first cycle the unit raises `busy_o` so that the pipeline stalls. The datapath then sees source 1 and source 2 as its operands, and the stage register captures the partial result at the clock edge. In the second cycle the datapath sees source 3 and source 2, except for rotates, which need source 1 again. The unit then raises `done_o` for one cycle with the final word on `result_o`. The stage register keeps its value until the next start. Funnel shifts take a 6-bit amount, and its top bit decides which source word leads.

Top module: `tern_bitop_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R2: A start accepted while the unit is idle raises `busy_o` in that same cycle and raises `done_o` in the next cycle, with `busy_o` low. `done_o` lasts exactly one cycle, and a new start is accepted in the cycle after it.
- R3: `result_o` is zero in every cycle in which `done_o` is low.
- R4: Opcode 0 (conditional mix) gives (rs1 AND rs2) OR (rs3 AND NOT rs2).
- R5: Opcode 1 (conditional move) gives rs1 when rs2 is nonzero and rs3 when rs2 is zero.
- R6: Opcode 3 (rotate right) rotates rs1 right by rs2[4:0]. Opcode 2 (rotate left) rotates rs1 left by rs2[4:0]. Bits rs2[31:5] have no effect.
- R7: A rotate by an amount of 0 returns rs1 unchanged in both directions.
- R8: Opcode 5 (funnel right) gives the low 32 bits of the 64-bit word {rs3, rs1} rotated right by rs2[5:0]. Bits rs2[31:6] have no effect.
- R9: Opcode 4 (funnel left) gives the high 32 bits of the 64-bit word {rs1, rs3} rotated left by rs2[5:0].
- R10: For both funnel shifts, an amount of 32 returns rs3 and an amount of 0 returns rs1.
- R11: `start_i` in the second cycle of an operation is ignored: the cycle after `done_o` has `done_o` and `busy_o` low when `start_i` is low there. Opcodes 6 and 7 follow the same two-cycle timing and give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_i | input | 3 | Operation code (0 mix, 1 move, 2 rotl, 3 rotr, 4 funnel left, 5 funnel right) |
| rs1_i | input | 32 | Source word 1 |
| rs2_i | input | 32 | Source word 2, also the shift amount |
| rs3_i | input | 32 | Source word 3 |
| result_o | output | 32 | Final result, valid while `done_o` is high |
| done_o | output | 1 | One-cycle pulse in the second cycle |
| busy_o | output | 1 | Stall request in the first cycle |

## Verification
The embedded properties that compare `result_o` with the source words assume one condition on the pipeline. The opcode and all three sources must not change between the first cycle and the second, because the second cycle reads them again rather than from a copy. Each bench scenario drives one operation at a falling edge and keeps the opcode and sources unchanged until after the `done_o` cycle has been sampled. It then either drops `start_i` or starts the next operation straight away. The restart scenario holds `start_i` high through the second cycle but does not change any source word.

// File: rtl/tbu_pkg.sv
`timescale 1ns/1ps
package tbu_pkg;
  localparam int OpW = 3;

  typedef enum logic [OpW-1:0] {
    OP_CMIX = 3'd0,
    OP_CMOV = 3'd1,
    OP_ROL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_FSL  = 3'd4,
    OP_FSR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } tbu_op_e;

  function automatic logic is_rotate(tbu_op_e op);
    return (op == OP_ROL) || (op == OP_ROR);
  endfunction
endpackage

// File: rtl/tbu_phase_ctrl.sv
`timescale 1ns/1ps
module tbu_phase_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic first_o,
  output logic second_o
);
  logic phase_q;

  assign first_o  = start_i & ~phase_q;
  assign second_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= first_o;
  end

  // R2: the second cycle always follows a first cycle
  p_second_after_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_o |-> $past(first_o));
  // R11: no first cycle can overlap a second cycle
  p_no_overlap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_o |-> !first_o);
endmodule

// File: rtl/tbu_first_step.sv
`timescale 1ns/1ps
module tbu_first_step #(
  parameter int Width = 32
) (
  input  tbu_pkg::tbu_op_e op_i,
  input  logic [Width-1:0] opa_i,
  input  logic [Width-1:0] opb_i,
  output logic [Width-1:0] part_o
);
  import tbu_pkg::*;
  localparam int ShW = $clog2(Width);

  function automatic logic [ShW-1:0] neg_amt(logic [ShW-1:0] amt);
    return ~amt + 1'b1;
  endfunction

  // x shifted left by (Width - amt); nothing when amt is zero
  function automatic logic [Width-1:0] cshl(logic [Width-1:0] x, logic [ShW-1:0] amt);
    return (amt == '0) ? '0 : (x << neg_amt(amt));
  endfunction

  // x shifted right by (Width - amt); nothing when amt is zero
  function automatic logic [Width-1:0] cshr(logic [Width-1:0] x, logic [ShW-1:0] amt);
    return (amt == '0) ? '0 : (x >> neg_amt(amt));
  endfunction

  logic [ShW-1:0] sh;
  logic           sh_hi;
  assign sh    = opb_i[ShW-1:0];
  assign sh_hi = opb_i[ShW];

  always_comb begin
    unique case (op_i)
      OP_CMIX: part_o = opa_i & opb_i;
      OP_CMOV: part_o = opa_i;
      OP_ROR:  part_o = opa_i >> sh;
      OP_ROL:  part_o = opa_i << sh;
      OP_FSR:  part_o = sh_hi ? cshl(opa_i, sh) : (opa_i >> sh);
      OP_FSL:  part_o = sh_hi ? cshr(opa_i, sh) : (opa_i << sh);
      default: part_o = '0;
    endcase
  end
endmodule

// File: rtl/tbu_second_step.sv
`timescale 1ns/1ps
module tbu_second_step #(
  parameter int Width = 32
) (
  input  tbu_pkg::tbu_op_e op_i,
  input  logic [Width-1:0] stage_i,
  input  logic [Width-1:0] opa_i,
  input  logic [Width-1:0] opb_i,
  output logic [Width-1:0] final_o
);
  import tbu_pkg::*;
  localparam int ShW = $clog2(Width);

  function automatic logic [ShW-1:0] neg_amt(logic [ShW-1:0] amt);
    return ~amt + 1'b1;
  endfunction

  function automatic logic [Width-1:0] cshl(logic [Width-1:0] x, logic [ShW-1:0] amt);
    return (amt == '0) ? '0 : (x << neg_amt(amt));
  endfunction

  function automatic logic [Width-1:0] cshr(logic [Width-1:0] x, logic [ShW-1:0] amt);
    return (amt == '0) ? '0 : (x >> neg_amt(amt));
  endfunction

  logic [ShW-1:0] sh;
  logic           sh_hi;
  assign sh    = opb_i[ShW-1:0];
  assign sh_hi = opb_i[ShW];

  always_comb begin
    unique case (op_i)
      OP_CMIX: final_o = stage_i | (opa_i & ~opb_i);
      OP_CMOV: final_o = (|opb_i) ? stage_i : opa_i;
      OP_ROR:  final_o = stage_i | cshl(opa_i, sh);
      OP_ROL:  final_o = stage_i | cshr(opa_i, sh);
      OP_FSR:  final_o = stage_i | (sh_hi ? (opa_i >> sh) : cshl(opa_i, sh));
      OP_FSL:  final_o = stage_i | (sh_hi ? (opa_i << sh) : cshr(opa_i, sh));
      default: final_o = '0;
    endcase
  end
endmodule

// File: rtl/tern_bitop_unit.sv
`timescale 1ns/1ps
module tern_bitop_unit #(
  parameter int Width = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [tbu_pkg::OpW-1:0]  op_i,
  input  logic [Width-1:0]         rs1_i,
  input  logic [Width-1:0]         rs2_i,
  input  logic [Width-1:0]         rs3_i,
  output logic [Width-1:0]         result_o,
  output logic                     done_o,
  output logic                     busy_o
);
  import tbu_pkg::*;

  // named internal events
  logic       first_cyc;
  logic       second_cyc;
  tbu_op_e    op_in;
  tbu_op_e    op_q;
  logic [Width-1:0] stage_q;
  logic [Width-1:0] part_d;
  logic [Width-1:0] final_w;
  logic [Width-1:0] opa_second;

  assign op_in = tbu_op_e'(op_i);

  tbu_phase_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .first_o  (first_cyc),
    .second_o (second_cyc)
  );

  tbu_first_step #(.Width(Width)) u_first (
    .op_i   (op_in),
    .opa_i  (rs1_i),
    .opb_i  (rs2_i),
    .part_o (part_d)
  );

  // second-cycle operand A: rs3 for three-source operations, rs1 again for rotates
  assign opa_second = is_rotate(op_q) ? rs1_i : rs3_i;

  tbu_second_step #(.Width(Width)) u_second (
    .op_i    (op_q),
    .stage_i (stage_q),
    .opa_i   (opa_second),
    .opb_i   (rs2_i),
    .final_o (final_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      op_q    <= OP_CMIX;
    end else if (first_cyc) begin
      stage_q <= part_d;
      op_q    <= op_in;
    end
  end

  assign busy_o   = first_cyc;
  assign done_o   = second_cyc;
  assign result_o = second_cyc ? final_w : '0;

  // Assertions assume that the opcode and sources stay stable across both cycles
  p_stall_then_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> done_o && !busy_o);
  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> result_o == '0);
  p_cmix_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_CMIX) |->
      result_o == (($past(rs1_i) & $past(rs2_i)) | (rs3_i & ~rs2_i)));
  p_cmov_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_CMOV) |->
      result_o == ((rs2_i != '0) ? $past(rs1_i) : rs3_i));
  p_rot_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_rotate(op_q) && rs2_i[$clog2(Width)-1:0] == '0) |->
      result_o == rs1_i);
  p_funnel_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_FSL || op_q == OP_FSR) &&
     rs2_i[$clog2(Width):0] == Width[$clog2(Width):0]) |-> result_o == rs3_i);
  p_reserved_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_RSV6 || op_q == OP_RSV7)) |-> result_o == '0);
endmodule

// File: tb/tern_bitop_unit_test.sv
`timescale 1ns/1ps
module tern_bitop_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [31:0] result;
  logic        done, busy;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tern_bitop_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .rs1_i(a), .rs2_i(b), .rs3_i(c),
    .result_o(result), .done_o(done), .busy_o(busy)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference: rotations built from doubled words
  function automatic logic [31:0] ref_ror(logic [31:0] x, int s);
    logic [63:0] d = {x, x};
    d = d >> s;
    return d[31:0];
  endfunction
  function automatic logic [31:0] ref_rol(logic [31:0] x, int s);
    logic [63:0] d = {x, x};
    d = d << s;
    return d[63:32];
  endfunction
  function automatic logic [31:0] ref_fsr(logic [31:0] p, logic [31:0] q, int s);
    logic [127:0] d = {q, p, q, p};
    d = d >> s;
    return d[31:0];
  endfunction
  function automatic logic [31:0] ref_fsl(logic [31:0] p, logic [31:0] q, int s);
    logic [127:0] d = {p, q, p, q};
    d = d << s;
    return d[127:96];
  endfunction

  // one full operation, start dropped after the done cycle
  task automatic run_op(string tag, logic [2:0] o, logic [31:0] x, logic [31:0] y,
                        logic [31:0] z, logic [31:0] exp);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; c = z;
    #1;
    chk({tag, " R2 busy first"}, {31'd0, busy}, 32'd1);
    chk({tag, " R3 idle result"}, result, 32'd0);
    @(negedge clk);
    chk({tag, " R2 done"}, {31'd0, done}, 32'd1);
    chk({tag, " R2 busy low"}, {31'd0, busy}, 32'd0);
    chk({tag, " result"}, result, exp);
    start = 1'b0;
    @(negedge clk);
    chk({tag, " R2 done pulse"}, {31'd0, done}, 32'd0);
    chk({tag, " R3 after"}, result, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 result", result, 32'd0);
  endtask

  task automatic t_cmix;
    run_op("R4 cmix a", 3'd0, 32'hF0F0_1234, 32'hFF00_FF00, 32'h0F0F_ABCD, 32'hF00F_12CD);
    run_op("R4 cmix b", 3'd0, 32'h0, 32'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
  endtask

  task automatic t_cmov;
    run_op("R5 cmov nz", 3'd1, 32'h1111_2222, 32'h0000_0100, 32'h3333_4444, 32'h1111_2222);
    run_op("R5 cmov z", 3'd1, 32'h1111_2222, 32'h0, 32'h3333_4444, 32'h3333_4444);
  endtask

  task automatic t_rotates;
    for (int s = 1; s < 32; s += 7) begin
      run_op("R6 ror", 3'd3, 32'h8123_4567, 32'hFFFF_FFE0 | s, 32'hAAAA_AAAA,
             ref_ror(32'h8123_4567, s));
      run_op("R6 rol", 3'd2, 32'h8123_4567, 32'h0000_0040 | s, 32'h5555_5555,
             ref_rol(32'h8123_4567, s));
    end
    run_op("R7 ror zero", 3'd3, 32'hCAFE_F00D, 32'h0000_0020, 32'hFFFF_FFFF, 32'hCAFE_F00D);
    run_op("R7 rol zero", 3'd2, 32'hCAFE_F00D, 32'h0, 32'hFFFF_FFFF, 32'hCAFE_F00D);
  endtask

  task automatic t_funnels;
    for (int s = 1; s < 64; s += 9) begin
      if (s == 32) continue;
      run_op("R8 fsr", 3'd5, 32'h1357_9BDF, 32'hABCD_0000 | s, 32'h2468_ACE0,
             ref_fsr(32'h1357_9BDF, 32'h2468_ACE0, s));
      run_op("R9 fsl", 3'd4, 32'h1357_9BDF, s, 32'h2468_ACE0,
             ref_fsl(32'h1357_9BDF, 32'h2468_ACE0, s));
    end
    run_op("R8 fsr 33", 3'd5, 32'h8000_0001, 32'd33, 32'hF000_000F,
           ref_fsr(32'h8000_0001, 32'hF000_000F, 33));
    run_op("R10 fsr 32", 3'd5, 32'h1234_5678, 32'd32, 32'h9ABC_DEF0, 32'h9ABC_DEF0);
    run_op("R10 fsr 0", 3'd5, 32'h1234_5678, 32'd0, 32'h9ABC_DEF0, 32'h1234_5678);
    run_op("R10 fsl 32", 3'd4, 32'h1234_5678, 32'h0000_00A0, 32'h9ABC_DEF0, 32'h9ABC_DEF0);
    run_op("R10 fsl 0", 3'd4, 32'h1234_5678, 32'h0000_0040, 32'h9ABC_DEF0, 32'h1234_5678);
  endtask

  task automatic t_restart_and_reserved;
    // start held through the second cycle must not launch a new operation
    @(negedge clk);
    start = 1'b1; op = 3'd3; a = 32'h0000_00F0; b = 32'd4; c = 32'h0;
    @(negedge clk);
    chk("R11 held start done", {31'd0, done}, 32'd1);
    chk("R11 held start result", result, 32'h0000_000F);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R11 no restart done", {31'd0, done}, 32'd0);
    chk("R11 no restart busy", {31'd0, busy}, 32'd0);
    run_op("R11 rsv6", 3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    run_op("R11 rsv7", 3'd7, 32'hFFFF_FFFF, 32'h1, 32'hFFFF_FFFF, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmix();
    t_cmov();
    t_rotates();
    t_funnels();
    t_restart_and_reserved();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule